// File: doc/BRIEF.md
# Two-Bank Level-Sensitive Interrupt Controller

This block collects sixty-four level-type interrupt sources and presents them to a processor as one request line. Sources are split into two banks of thirty-two: sources 0 to 31 form the low bank and sources 32 to 63 form the high bank. Each bank holds a latched flag per source and a separate enable mask. Software acknowledges a source by writing a one to its bit in the bank's clear register. A read-only status register shows which latched flags are also enabled.

The request line is the registered OR of every status bit in both banks. A priority encoder next to it reports the number of the lowest pending enabled source, and a valid flag qualifies that number. Every low-bank source ranks ahead of every high-bank source. A handler can read the index, service that source, acknowledge it, and repeat until the valid flag drops.

Software reaches the registers through a simple synchronous port with separate read and write strobes. The offsets below are byte addresses on `addr`.

Top module: `irq_ctrl_2bank`

## Requirements
- R1: After reset all flags and all enables are zero, and `irq_o`, `pend_valid` and `rdata` read zero.
- R2: A flag bit becomes 1 at any rising clock edge where its source input is high. This holds even when a clear write to the same bit happens at the same edge, because the set wins.
- R3: Writing to offset 0x00 clears the low-bank flags whose `wdata` bit is 1, with bit n standing for source n. Writing to offset 0x04 does the same for the high bank, with bit n standing for source 32+n. Zero bits in the written word leave their flags unchanged.
- R4: A source whose input is still high when it is acknowledged is pending again after the clear.
- R5: The enable registers sit at offset 0x10 for the low bank and 0x14 for the high bank. They are read-write. Bit n set to 1 unmasks the matching source, and bit n cleared to 0 masks it.
- R6: The status registers sit at offset 0x18 for the low bank and 0x1C for the high bank. Each reads as the bank's flags ANDed with its enables.
- R7: `irq_o` is registered. It equals the OR of all status bits as they stood one clock edge earlier.
- R8: `pend_valid` is 1 when any status bit is set. `pend_idx` then gives the lowest pending source number: the bit position for a low-bank source, or 32 plus the bit position for a high-bank source. Any low-bank source wins over any high-bank source.
- R9: When both enable registers are zero, no source raises `irq_o` or `pend_valid`, even with flags latched.
- R10: Reads of the clear offsets and of unmapped offsets return zero. Writes to the status offsets and to unmapped offsets change nothing.
- R11: `rdata` carries the addressed register's value in the cycle after `rd_en` is sampled high. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 64 | Level interrupt sources; bit k is source k |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request to the processor |
| pend_idx | output | 6 | Number of the lowest pending enabled source |
| pend_valid | output | 1 | High when `pend_idx` is meaningful |

## Verification
A corrupted flag or enable bit reaches the ports without delay through `pend_valid` and `pend_idx`. It reaches `irq_o` one edge later, and it shows in the next status or enable read. A flag that is lost, left stuck, or cleared by the wrong bank therefore changes the reported lowest index within a cycle. This happens as long as no lower-numbered source hides it. A wrong bank priority shows whenever sources in both banks are pending together. The random stream keeps source activity sparse and clears often, so lone pending bits in either bank occur regularly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_BANKS = 2;

  // Byte offsets per bank; bank b sits 4*b above the bank-0 offset.
  localparam int unsigned OFS_CLR_BASE = 'h00;
  localparam int unsigned OFS_EN_BASE  = 'h10;
  localparam int unsigned OFS_ST_BASE  = 'h18;
  localparam int unsigned OFS_STRIDE   = 4;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] clr,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] status
);
  logic [W-1:0] flag_d;
  logic [W-1:0] en_d;

  always_comb begin
    flag_d = (flag_q & ~clr) | src;   // set has priority over clear
    en_d   = en_we ? en_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_we) en_q <= en_d;
    end
  end

  assign status = flag_q & en_q;
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [W-1:0]                  wdata,
  input  logic [NUM_BANKS-1:0][W-1:0]   en_q,
  input  logic [NUM_BANKS-1:0][W-1:0]   status,
  output logic [NUM_BANKS-1:0][W-1:0]   clr,
  output logic [NUM_BANKS-1:0]          en_we,
  output logic [W-1:0]                  rdata
);
  logic [NUM_BANKS-1:0] hit_clr, hit_en, hit_st;
  logic [W-1:0]         rd_d;
  logic [W-1:0]         rdata_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign hit_clr[b] = (addr == ADDR_W'(OFS_CLR_BASE + b * OFS_STRIDE));
    assign hit_en[b]  = (addr == ADDR_W'(OFS_EN_BASE  + b * OFS_STRIDE));
    assign hit_st[b]  = (addr == ADDR_W'(OFS_ST_BASE  + b * OFS_STRIDE));
    assign clr[b]     = (wr_en && hit_clr[b]) ? wdata : '0;
    assign en_we[b]   = wr_en && hit_en[b];
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit_en[b]) rd_d = en_q[b];
      if (hit_st[b]) rd_d = status[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_en ? rd_d : '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  always_comb begin
    idx   = '0;
    valid = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_2bank.sv
module irq_ctrl_2bank
  import irqc_pkg::*;
#(
  parameter int unsigned BANK_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned N     = NUM_BANKS * BANK_W,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] rdata,
  output logic              irq_o,
  output logic [IDX_W-1:0]  pend_idx,
  output logic              pend_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_BANKS-1:0][BANK_W-1:0] clr_b, flag_b, en_b, st_b;
  logic [NUM_BANKS-1:0]             en_we_b;
  logic [N-1:0]                     flag_all, en_all, status_all, clr_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .src      (src_i[b*BANK_W +: BANK_W]),
      .clr      (clr_b[b]),
      .en_we    (en_we_b[b]),
      .en_wdata (wdata),
      .flag_q   (flag_b[b]),
      .en_q     (en_b[b]),
      .status   (st_b[b])
    );
    assign flag_all[b*BANK_W +: BANK_W]   = flag_b[b];
    assign en_all[b*BANK_W +: BANK_W]     = en_b[b];
    assign status_all[b*BANK_W +: BANK_W] = st_b[b];
    assign clr_all[b*BANK_W +: BANK_W]    = clr_b[b];
  end

  irqc_regif #(.ADDR_W(ADDR_W), .W(BANK_W)) u_regif (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .en_q   (en_b),
    .status (st_b),
    .clr    (clr_b),
    .en_we  (en_we_b),
    .rdata  (rdata)
  );

  irqc_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
    .req   (status_all),
    .idx   (pend_idx),
    .valid (pend_valid)
  );

  logic irq_q, irq_d;
  assign irq_d = |status_all;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     src_i,
  input logic             wr_en,
  input logic [N-1:0]     flag_all,
  input logic [N-1:0]     en_all,
  input logic [N-1:0]     clr_all,
  input logic [IDX_W-1:0] pend_idx,
  input logic             pend_valid,
  input logic             irq_o
);
  logic         armed;
  logic [N-1:0] below;
  logic [N-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    below   = ({{(N-1){1'b0}}, 1'b1} << pend_idx) - {{(N-1){1'b0}}, 1'b1};
    pending = flag_all & en_all;
  end

  AST_SRC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((flag_all & $past(src_i)) == $past(src_i)));                  // R2

  AST_FLAG_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(flag_all) & ~flag_all & ~$past(clr_all)) == '0));       // R3

  AST_EN_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wr_en)) |-> $stable(en_all));                           // R5

  AST_IRQ_LAGS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_o == $past(pend_valid)));                                 // R7

  AST_IDX_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (flag_all[pend_idx] && en_all[pend_idx]));                // R8

  AST_IDX_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((pending & below) == '0));                               // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !pend_valid);                                         // R9
endmodule

bind irq_ctrl_2bank irqc_checker #(.N(N), .IDX_W(IDX_W)) u_irqc_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .src_i      (src_i),
  .wr_en      (wr_en),
  .flag_all   (flag_all),
  .en_all     (en_all),
  .clr_all    (clr_all),
  .pend_idx   (pend_idx),
  .pend_valid (pend_valid),
  .irq_o      (irq_o)
);

// File: tb/test_irq_ctrl_2bank.sv
`timescale 1ns/1ps
module test_irq_ctrl_2bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_i;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;
  logic [5:0]  pend_idx;
  logic        pend_valid;

  int errors = 0;
  int checks = 0;

  logic [63:0] m_flag, m_en;

  always #2 clk = ~clk;

  irq_ctrl_2bank i_irq_ctrl_2bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .pend_idx(pend_idx), .pend_valid(pend_valid)
  );

  function automatic logic [31:0] f_read(logic [7:0] a, logic [63:0] fl, logic [63:0] en);
    case (a)
      8'h10: return en[31:0];
      8'h14: return en[63:32];
      8'h18: return fl[31:0] & en[31:0];
      8'h1C: return fl[63:32] & en[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic int f_lowest(logic [63:0] st);
    for (int i = 0; i < 64; i++) if (st[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One clock: model update and port checks. Inputs already driven.
  task automatic step();
    logic [63:0] clr, st;
    logic        exp_irq;
    logic [31:0] exp_rd;
    int          lo;
    clr = '0;
    if (wr_en && addr == 8'h00) clr[31:0]  = wdata;
    if (wr_en && addr == 8'h04) clr[63:32] = wdata;
    exp_irq = |(m_flag & m_en);
    exp_rd  = rd_en ? f_read(addr, m_flag, m_en) : 32'h0;
    m_flag  = (m_flag & ~clr) | src_i;
    if (wr_en && addr == 8'h10) m_en[31:0]  = wdata;
    if (wr_en && addr == 8'h14) m_en[63:32] = wdata;
    @(posedge clk);
    @(negedge clk);
    st = m_flag & m_en;
    lo = f_lowest(st);
    chk(irq_o == exp_irq, "R7 irq_o", 64'(irq_o), 64'(exp_irq));
    chk(rdata == exp_rd, "R11 rdata", 64'(rdata), 64'(exp_rd));
    chk(pend_valid == (lo >= 0), "R8 pend_valid", 64'(pend_valid), 64'(lo >= 0));
    if (lo >= 0) chk(pend_idx == 6'(lo), "R8 pend_idx", 64'(pend_idx), 64'(lo));
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; addr = 8'h0; wdata = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    step();
    idle();
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    wr_en = 0; rd_en = 1; addr = a; wdata = '0;
    step();
    d = rdata;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 0; src_i = '0; idle();
    m_flag = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(irq_o == 0, "R1 irq_o", 64'(irq_o), 0);
    chk(pend_valid == 0, "R1 pend_valid", 64'(pend_valid), 0);
    chk(rdata == 0, "R1 rdata", 64'(rdata), 0);
    rd(8'h10, d); chk(d == 0, "R1 en low", 64'(d), 0);
    rd(8'h14, d); chk(d == 0, "R1 en high", 64'(d), 0);
    rd(8'h1C, d); chk(d == 0, "R1 status high", 64'(d), 0);

    // R9: all flags latched, enables zero
    wr(8'h10, 32'h0); wr(8'h14, 32'h0);
    src_i = '1; step(); src_i = '0;
    step();
    chk(pend_valid == 0, "R9 pend_valid", 64'(pend_valid), 0);
    chk(irq_o == 0, "R9 irq_o", 64'(irq_o), 0);
    rd(8'h18, d); chk(d == 0, "R9 status low", 64'(d), 0);

    // R5/R8: high source 37 alone, then low source 9 takes over
    wr(8'h14, 32'h20);
    chk(pend_valid && pend_idx == 6'd37, "R8 high bank idx", 64'(pend_idx), 37);
    step();
    chk(irq_o == 1, "R7 irq raised", 64'(irq_o), 1);
    wr(8'h10, 32'h200);
    chk(pend_idx == 6'd9, "R8 low bank first", 64'(pend_idx), 9);
    rd(8'h10, d); chk(d == 32'h200, "R5 en low readback", 64'(d), 64'h200);
    rd(8'h18, d); chk(d == 32'h200, "R6 status low", 64'(d), 64'h200);
    rd(8'h1C, d); chk(d == 32'h20, "R6 status high", 64'(d), 64'h20);

    // R3: clear low source 9, zero write leaves high bank alone
    wr(8'h00, 32'h200);
    chk(pend_idx == 6'd37, "R3 low clear", 64'(pend_idx), 37);
    wr(8'h04, 32'h0);
    chk(pend_valid && pend_idx == 6'd37, "R3 zero bits keep", 64'(pend_idx), 37);

    // R2/R4: set wins over clear; still-high source re-pends
    src_i = 64'h1 << 37;
    wr(8'h04, 32'h20);
    chk(pend_valid && pend_idx == 6'd37, "R2 set wins", 64'(pend_valid), 1);
    wr(8'h04, 32'h20);
    chk(pend_valid == 1, "R4 level repends", 64'(pend_valid), 1);
    src_i = '0;
    wr(8'h04, 32'h20);
    chk(pend_idx != 6'd37 || !pend_valid, "R3 high clear", 64'(pend_idx), 9);

    // R10: writes to status and unmapped offsets ignored; reads return zero
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h10, d); chk(d == 32'h200, "R10 en low untouched", 64'(d), 64'h200);
    rd(8'h14, d); chk(d == 32'h20, "R10 en high untouched", 64'(d), 64'h20);
    rd(8'h00, d); chk(d == 0, "R10 clear reads zero", 64'(d), 0);
    rd(8'h08, d); chk(d == 0, "R10 unmapped read", 64'(d), 0);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] sel;
      src_i = ($urandom_range(0, 3) == 0)
              ? ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom})
              : 64'h0;
      wr_en = ($urandom_range(0, 2) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 8))
        0: sel = 8'h00; 1: sel = 8'h04; 2: sel = 8'h10; 3: sel = 8'h14;
        4: sel = 8'h18; 5: sel = 8'h1C; 6: sel = 8'h08;
        7: sel = 8'h00; default: sel = 8'($urandom);
      endcase
      addr  = sel;
      wdata = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom;
      step();
    end
    src_i = '0; idle();

    summary();
    $finish;
  end
endmodule